// File: doc/BRIEF.md
# Burst Register Transfer Stall Estimator

This block works out the extra cycles that a multi-register transfer costs. A transfer moves registers 0 through a given highest index to or from consecutive 32-bit words starting at a base address. Each request carries the base address, the highest register index, a direction bit and two history masks from the hazard unit. The history masks mark the registers written by the previous instruction and by the one before it.

Two separate penalties are reported. The first is a line penalty: one cycle for each 32-byte cache line boundary that the burst crosses, up to two. The second is a source penalty, which applies to stores only. It is raised when a register being stored was written recently. For loads, the block also reports the mask of registers that the transfer overwrites. A store that would cross more than two boundaries sets a sticky error flag, which only reset clears.

All results are computed combinationally and captured in one output register stage. That stage is qualified by a valid bit and holds its value while no request arrives.

Top module: `burst_xfer_stall`

## Requirements
- R1: After a synchronous active-high reset, `res_valid`, `res_error`, both stall counts and `res_load_mask` are all zero.
- R2: If the first byte at `req_base` and the last byte at `req_base + 4*(req_top+1) - 1` fall in the same 32-byte line (same value of address bits 31:5), `res_line_stall` is 0.
- R3: If the last byte's line index exceeds the first byte's by 1, `res_line_stall` is 1. If it exceeds it by 2, `res_line_stall` is 2. This holds for both directions, and no stall count ever reads 3.
- R4: If the line index difference exceeds 2, `res_line_stall` is 0. For a store (`req_store`=1) this sets `res_error`. For a load (`req_store`=0) `res_error` is not affected.
- R5: `res_error` stays set through idle cycles and later requests until reset.
- R6: For a store, `res_src_stall` is 2 when any of registers 0..`req_top` is set in `hist_prev`. This takes precedence over `hist_prev2`.
- R7: For a store with no such register in `hist_prev`, `res_src_stall` is 1 if any of registers 0..`req_top` is set in `hist_prev2`, and 0 otherwise. History bits above `req_top` have no effect.
- R8: For a load, `res_src_stall` is 0 whatever the history, and `res_load_mask` has exactly bits 0..`req_top` set. For a store, `res_load_mask` is 0.
- R9: The results of a request taken at a rising edge appear at that edge, with `res_valid`=1. When `req_valid` is 0, `res_valid` falls and the other results hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| req_base | input | ADDR_W (32) | Byte address of the first word |
| req_top | input | IDX_W (5) | Highest register index moved |
| hist_prev | input | NREG (32) | Registers written by the previous instruction |
| hist_prev2 | input | NREG (32) | Registers written two instructions back |
| res_valid | output | 1 | Results below belong to a request |
| res_line_stall | output | 2 | Line-crossing stall cycles |
| res_src_stall | output | 2 | Store source-hazard stall cycles |
| res_load_mask | output | NREG (32) | Registers overwritten by a load |
| res_error | output | 1 | Sticky: a store spanned more than three lines |

## Verification
A wrong line-difference calculation shows up one edge after the request as a line stall that is off by one cycle. It also shows up as an error flag that is raised or missing, most clearly for bursts that begin in the last word of a line. A wrong precedence or mask width in the hazard check shows up in the same cycle as a source stall of 1 where 2 is expected, or a nonzero stall caused by history bits above the top register. A sticky flag that leaks is visible on the first idle cycle after the error, and a sticky flag that does not clear is visible right after the next reset.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef logic [1:0] stall_t;
  localparam stall_t STALL_NONE = 2'd0;
  localparam stall_t STALL_ONE  = 2'd1;
  localparam stall_t STALL_TWO  = 2'd2;
  localparam int     MAX_PAID_CROSSINGS = 2;
endpackage

// File: rtl/bxs_span_calc.sv
module bxs_span_calc #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 5,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  top_i,
  output bxs_pkg::stall_t   line_stall_o,
  output logic              too_wide_o
);
  import bxs_pkg::*;

  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int EXT_W  = ADDR_W + 1;
  localparam int LINE_W = EXT_W - OFS_W;

  logic [EXT_W-1:0]  nbytes;
  logic [EXT_W-1:0]  last_byte;
  logic [LINE_W-1:0] first_line;
  logic [LINE_W-1:0] last_line;
  logic [LINE_W-1:0] crossings;

  always_comb begin
    nbytes     = (EXT_W'(top_i) + EXT_W'(1)) * EXT_W'(WORD_BYTES);
    last_byte  = {1'b0, base_i} + nbytes - EXT_W'(1);
    first_line = LINE_W'({1'b0, base_i} >> OFS_W);
    last_line  = LINE_W'(last_byte >> OFS_W);
    crossings  = last_line - first_line;
  end

  always_comb begin
    too_wide_o   = 1'b0;
    line_stall_o = STALL_NONE;
    if (crossings == LINE_W'(1))
      line_stall_o = STALL_ONE;
    else if (crossings == LINE_W'(MAX_PAID_CROSSINGS))
      line_stall_o = STALL_TWO;
    else if (crossings > LINE_W'(MAX_PAID_CROSSINGS))
      too_wide_o = 1'b1;
  end
endmodule

// File: rtl/bxs_reg_mask.sv
module bxs_reg_mask #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [IDX_W-1:0] top_i,
  output logic [NREG-1:0]  mask_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_bit
    assign mask_o[g] = (IDX_W'(g) <= top_i);
  end
endmodule

// File: rtl/bxs_src_hazard.sv
module bxs_src_hazard #(
  parameter int NREG = 32
) (
  input  logic            en_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [NREG-1:0] prev_i,
  input  logic [NREG-1:0] prev2_i,
  output bxs_pkg::stall_t stall_o
);
  import bxs_pkg::*;

  logic hit_prev;
  logic hit_prev2;

  assign hit_prev  = |(prev_i & mask_i);
  assign hit_prev2 = |(prev2_i & mask_i);

  always_comb begin
    stall_o = STALL_NONE;
    if (en_i) begin
      if (hit_prev)
        stall_o = STALL_TWO;
      else if (hit_prev2)
        stall_o = STALL_ONE;
    end
  end
endmodule

// File: rtl/burst_xfer_stall.sv
module burst_xfer_stall #(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IDX_W-1:0]  req_top,
  input  logic [NREG-1:0]   hist_prev,
  input  logic [NREG-1:0]   hist_prev2,
  output logic              res_valid,
  output logic [1:0]        res_line_stall,
  output logic [1:0]        res_src_stall,
  output logic [NREG-1:0]   res_load_mask,
  output logic              res_error
);
  import bxs_pkg::*;

  stall_t          line_stall_c;
  stall_t          src_stall_c;
  logic            too_wide_c;
  logic [NREG-1:0] span_mask_c;

  bxs_span_calc #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES)
  ) i_span (
    .base_i      (req_base),
    .top_i       (req_top),
    .line_stall_o(line_stall_c),
    .too_wide_o  (too_wide_c)
  );

  bxs_reg_mask #(
    .NREG (NREG),
    .IDX_W(IDX_W)
  ) i_mask (
    .top_i (req_top),
    .mask_o(span_mask_c)
  );

  bxs_src_hazard #(
    .NREG(NREG)
  ) i_haz (
    .en_i   (req_store),
    .mask_i (span_mask_c),
    .prev_i (hist_prev),
    .prev2_i(hist_prev2),
    .stall_o(src_stall_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_line_stall <= STALL_NONE;
      res_src_stall  <= STALL_NONE;
      res_load_mask  <= '0;
      res_error      <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_line_stall <= line_stall_c;
        res_src_stall  <= src_stall_c;
        res_load_mask  <= req_store ? '0 : span_mask_c;
        if (req_store && too_wide_c)
          res_error <= 1'b1;
      end
    end
  end

  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(req_valid && !rst)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(req_valid) && !$past(rst)) |-> ($stable(res_line_stall) && $stable(res_load_mask))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(res_error) && !$past(rst)) |-> res_error); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(res_error) |-> $past(req_valid && req_store)); // R4
  AST_STALL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (res_line_stall != 2'd3) && (res_src_stall != 2'd3)); // R3
  AST_LOAD_NO_SRC: assert property (@(posedge clk) disable iff (rst)
    (res_load_mask != '0) |-> (res_src_stall == STALL_NONE && res_load_mask[0])); // R8
endmodule

// File: tb/test_burst_xfer_stall.sv
module test_burst_xfer_stall;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_store;
  logic [31:0] req_base;
  logic [4:0]  req_top;
  logic [31:0] hist_prev;
  logic [31:0] hist_prev2;
  logic        res_valid;
  logic [1:0]  res_line_stall;
  logic [1:0]  res_src_stall;
  logic [31:0] res_load_mask;
  logic        res_error;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  burst_xfer_stall i_burst_xfer_stall (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_base(req_base), .req_top(req_top), .hist_prev(hist_prev),
    .hist_prev2(hist_prev2), .res_valid(res_valid),
    .res_line_stall(res_line_stall), .res_src_stall(res_src_stall),
    .res_load_mask(res_load_mask), .res_error(res_error)
  );

  typedef struct packed {
    logic        st;
    logic [31:0] base;
    logic [4:0]  top;
    logic [31:0] prev;
    logic [31:0] prev2;
    logic [1:0]  eline;
    logic [1:0]  esrc;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    {1'b0, 32'h0000_0100, 5'd7,  32'h0,        32'h0,  2'd0, 2'd0}, // R2 one full line
    {1'b0, 32'h0000_0104, 5'd7,  32'h0,        32'h0,  2'd1, 2'd0}, // R3 one crossing
    {1'b0, 32'h0000_011C, 5'd15, 32'h0000_FFFF, 32'h0, 2'd2, 2'd0}, // R3 two crossings, R8
    {1'b1, 32'h0000_0200, 5'd3,  32'h0000_0008, 32'h0, 2'd0, 2'd2}, // R6
    {1'b1, 32'h0000_021C, 5'd1,  32'h0000_0001, 32'h2, 2'd1, 2'd2}, // R6 precedence
    {1'b1, 32'h0000_0210, 5'd3,  32'h0,        32'h4,  2'd0, 2'd1}, // R7
    {1'b1, 32'h0000_0000, 5'd2,  32'h0000_0008, 32'h10, 2'd0, 2'd0}, // R7 bits above top
    {1'b1, 32'h0000_03F8, 5'd13, 32'h0,        32'h0,  2'd2, 2'd0}, // R3 store
    {1'b0, 32'h0000_0000, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 2'd0}, // R4 load too wide
    {1'b0, 32'h0000_001C, 5'd0,  32'h0,        32'h0,  2'd0, 2'd0}, // R2 last word
    {1'b1, 32'hFFFF_FFFC, 5'd1,  32'h0,        32'h0,  2'd1, 2'd0}  // R3 top of space
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic [31:0] base, input logic [4:0] top,
                       input logic [31:0] p, input logic [31:0] p2);
    @(negedge clk);
    req_valid  = 1'b1;
    req_store  = st;
    req_base   = base;
    req_top    = top;
    hist_prev  = p;
    hist_prev2 = p2;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  function automatic logic [31:0] low_mask(input logic [4:0] top);
    logic [32:0] m;
    m = (33'd1 << (top + 6'd1)) - 33'd1;
    return m[31:0];
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_base = '0;
    req_top = '0; hist_prev = '0; hist_prev2 = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, res_valid}, 32'd0);
    check("R1 error", {31'd0, res_error}, 32'd0);
    check("R1 line", {30'd0, res_line_stall}, 32'd0);
    check("R1 src", {30'd0, res_src_stall}, 32'd0);
    check("R1 mask", res_load_mask, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].st, VECS[i].base, VECS[i].top, VECS[i].prev, VECS[i].prev2);
      check($sformatf("R9 valid vec%0d", i), {31'd0, res_valid}, 32'd1);
      check($sformatf("R2/R3 line vec%0d", i), {30'd0, res_line_stall}, {30'd0, VECS[i].eline});
      check($sformatf("R6/R7 src vec%0d", i), {30'd0, res_src_stall}, {30'd0, VECS[i].esrc});
      check($sformatf("R8 mask vec%0d", i), res_load_mask,
            VECS[i].st ? 32'd0 : low_mask(VECS[i].top));
    end
    check("R4 load leaves error clear", {31'd0, res_error}, 32'd0);

    // R4 store spanning four lines: 4 + 96 - 1 = 99 -> three crossings
    issue(1'b1, 32'h0000_0004, 5'd23, 32'h0, 32'h0);
    check("R4 store error", {31'd0, res_error}, 32'd1);
    check("R4 line zero", {30'd0, res_line_stall}, 32'd0);

    // R9 idle: valid drops, results held
    @(negedge clk);
    check("R9 valid low", {31'd0, res_valid}, 32'd0);
    check("R9 line held", {30'd0, res_line_stall}, 32'd0);
    check("R5 error held idle", {31'd0, res_error}, 32'd1);

    issue(1'b0, 32'h0000_0104, 5'd7, 32'h0, 32'h0);
    check("R5 error held after request", {31'd0, res_error}, 32'd1);
    check("R3 line after error", {30'd0, res_line_stall}, 32'd1);
    @(negedge clk);
    check("R9 line held at 1", {30'd0, res_line_stall}, 32'd1);
    check("R9 mask held", res_load_mask, 32'h0000_00FF);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R5 reset clears error", {31'd0, res_error}, 32'd0);
    check("R1 mask after reset", res_load_mask, 32'd0);

    // R4 store at full width: 127 -> three crossings
    issue(1'b1, 32'h0000_0000, 5'd31, 32'h0, 32'h0);
    check("R4 full-width store error", {31'd0, res_error}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule